// File: doc/BRIEF.md
# Random Word Prefetch Holder

This block keeps one random word ready for software. A write strobe to a prefetch control location tells the block to get a fresh word from an external entropy source. The block does this through a request/acknowledge handshake and holds the word until it is read. A read of the random location returns the held word and consumes it, which leaves the holder empty.

When a read finds the holder empty, the block stalls the reader until a word arrives. If no fetch is outstanding at that point, the block starts one. Software therefore needs no prefetch before a read. A prefetch only reduces the stall.

Extra prefetches are absorbed: they neither stack requests nor throw away a word that is already held. The held word can be returned at full width. It can also be returned through a narrow path, which gives only its low bits, zero-extended.

Top module: `rnd_prefetch_reg`

## Requirements
- R1: After a synchronous active-low reset, the holder is empty and `ent_req_o` is low. `rd_stall_o` is low while `rd_req_i` is low. A read issued right after reset stalls.
- R2: A prefetch strobe that arrives while the holder is empty and no fetch is outstanding raises `ent_req_o` at the next clock edge. `ent_req_o` stays high until the cycle in which `ent_ack_i` is high. The word on `ent_data_i` in that cycle is the one that is held.
- R3: A prefetch strobe that arrives while a fetch is outstanding causes no further request. After the acknowledge, `ent_req_o` is low and stays low.
- R4: A prefetch strobe that arrives while a word is held, in a cycle with no completing read, is ignored. The held word is kept and no request is issued.
- R5: A read of a held word completes in the same cycle, with `rd_stall_o` low and the word on `rd_data_o`. The word is consumed, so the next read stalls. `rd_data_o` is zero in every cycle that does not complete a read.
- R6: A read issued after a prefetch but before the word arrives keeps `rd_stall_o` high until the cycle after the acknowledge. In that cycle the read completes with the arrived word.
- R7: A read that finds the holder empty with no fetch outstanding raises `ent_req_o` at the next edge. It stalls until the word arrives and is then returned.
- R8: With `rd_wide_i` = 1, the whole word is returned. With `rd_wide_i` = 0, bits [NARROW_W-1:0] of the word are returned and all upper bits of `rd_data_o` are zero. Both kinds of read consume the word.
- R9: A prefetch strobe in the same cycle as a read that consumes the held word starts a new fetch. `ent_req_o` rises at the next edge.
- R10: `ent_ack_i` is ignored while `ent_req_o` is low: no word is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| prefetch_wr_i | input | 1 | One-cycle strobe from a write to the prefetch control location |
| rd_req_i | input | 1 | Read of the random location, held high until `rd_stall_o` is low |
| rd_wide_i | input | 1 | 1 selects the full-width read path, 0 selects the narrow path |
| rd_stall_o | output | 1 | High while a read is pending and no word is held |
| rd_data_o | output | RND_W | Returned word, valid in a cycle where `rd_req_i` is high and `rd_stall_o` is low |
| ent_req_o | output | 1 | Request to the entropy source |
| ent_ack_i | input | 1 | Acknowledge from the entropy source; data is valid in the same cycle |
| ent_data_i | input | RND_W | Random word from the entropy source |

## Verification
The bench builds the block with RND_W = 64 and NARROW_W = 16. These are unequal widths, so the zero-extension of a narrow read can be seen on 48 upper bits. The word size is also small enough to write distinct patterns directly into the vector table. The table steps through every mix of prefetch, read, acknowledge and stray acknowledge against empty, pending and full holder states. Directed tests then hold a request unanswered over many cycles and apply a reset in the middle of a fetch.

// File: rtl/rnd_pf_pkg.sv
// Package: shared types for the random-word prefetch holder.
// Assumes: nothing beyond IEEE 1800-2017.
package rnd_pf_pkg;

    // Fetch controller state: idle, or waiting for the entropy acknowledge.
    typedef enum logic {
        FETCH_IDLE = 1'b0,
        FETCH_WAIT = 1'b1
    } fetch_state_e;

    // Mask that keeps the low narrow bits of a wide word.
    function automatic logic [255:0] low_mask(input int unsigned narrow);
        logic [255:0] m;
        m = '0;
        for (int i = 0; i < 256; i++) begin
            if (i < narrow) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/rnd_pf_fetch_ctrl.sv
// Module: fetch controller. It starts one entropy request when asked and
// keeps it raised until acknowledged. Requests made while one is already
// outstanding are absorbed.
// Assumes: the entropy source drives data in the same cycle as its acknowledge.
module rnd_pf_fetch_ctrl
    import rnd_pf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic want_i,
    input  logic ack_i,
    output logic req_o,
    output logic capture_o
);

    fetch_state_e state_q;
    fetch_state_e state_d;

    // Next-state logic: leave idle on a fetch wish, return on acknowledge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FETCH_IDLE: if (want_i) state_d = FETCH_WAIT;
            FETCH_WAIT: if (ack_i)  state_d = FETCH_IDLE;
            default:    state_d = FETCH_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= FETCH_IDLE;
        else         state_q <= state_d;
    end

    // Outputs: the request is the wait state; capture needs the acknowledge too.
    assign req_o     = (state_q == FETCH_WAIT);
    assign capture_o = req_o & ack_i;

    assert_req_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && !ack_i) |=> req_o);

    assert_single_request_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        capture_o |=> !req_o);

    assert_stray_ack_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_o && ack_i) |-> !capture_o);

endmodule

// File: rtl/rnd_pf_hold.sv
// Module: holding register for one random word with a valid flag.
// Capture loads the word and sets valid. Consume clears valid.
// Assumes: capture and consume never happen in the same cycle. The top
// ensures this by fetching only into an empty or emptying holder.
module rnd_pf_hold #(
    parameter int unsigned W = 256
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         capture_i,
    input  logic [W-1:0] cap_data_i,
    input  logic         consume_i,
    output logic         valid_o,
    output logic [W-1:0] data_o
);

    logic         valid_q;
    logic [W-1:0] data_q;

    // Valid flag: set on capture, cleared on consume.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        valid_q <= 1'b0;
        else if (capture_i) valid_q <= 1'b1;
        else if (consume_i) valid_q <= 1'b0;
    end

    // Word storage: loaded only on capture.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        data_q <= '0;
        else if (capture_i) data_q <= cap_data_i;
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;

    assert_no_overwrite_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        capture_i |-> !valid_q);

    assert_held_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_q && !consume_i) |=> (valid_q && $stable(data_q)));

    assert_consume_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        consume_i |=> !valid_q);

endmodule

// File: rtl/rnd_pf_rd_mux.sv
// Module: read-path selector. It returns the full word, or only its low
// NARROW_W bits zero-extended. The output is zero when no read completes.
// Assumes: NARROW_W <= WIDE_W <= 256.
module rnd_pf_rd_mux
    import rnd_pf_pkg::*;
#(
    parameter int unsigned WIDE_W   = 256,
    parameter int unsigned NARROW_W = 32
) (
    input  logic              fire_i,
    input  logic              sel_wide_i,
    input  logic [WIDE_W-1:0] data_i,
    output logic [WIDE_W-1:0] data_o
);

    localparam logic [255:0]        FULL_MASK   = low_mask(NARROW_W);
    localparam logic [WIDE_W-1:0]   NARROW_MASK = FULL_MASK[WIDE_W-1:0];

    // Width selection and gating by read completion.
    always_comb begin
        if (!fire_i)        data_o = '0;
        else if (sel_wide_i) data_o = data_i;
        else                data_o = data_i & NARROW_MASK;
    end

    generate
        if (NARROW_W < WIDE_W) begin : g_narrow_check
            // Upper bits must be zero on the narrow path.
            always_comb begin
                if (fire_i && !sel_wide_i) begin
                    assert_narrow_zero_ext_R8: assert (data_o[WIDE_W-1:NARROW_W] == '0);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rnd_prefetch_reg.sv
// Module: random-word prefetch holder (top).
// A prefetch strobe fetches a word into an empty holder. A read returns
// and consumes the held word. A read of an empty holder stalls and, if
// needed, starts the fetch itself.
// Assumes: rd_req_i is held until rd_stall_o is low, and the entropy source
// follows the request/acknowledge handshake.
module rnd_prefetch_reg #(
    parameter int unsigned RND_W    = 256,
    parameter int unsigned NARROW_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             prefetch_wr_i,
    input  logic             rd_req_i,
    input  logic             rd_wide_i,
    output logic             rd_stall_o,
    output logic [RND_W-1:0] rd_data_o,
    output logic             ent_req_o,
    input  logic             ent_ack_i,
    input  logic [RND_W-1:0] ent_data_i
);

    logic             held_valid;
    logic [RND_W-1:0] held_data;
    logic             consume;
    logic             want_fetch;
    logic             capture;

    // Read handshake: complete on a held word, otherwise stall.
    always_comb begin
        consume    = rd_req_i & held_valid;
        rd_stall_o = rd_req_i & ~held_valid;
    end

    // Fetch wish: a prefetch into an empty or emptying holder, or a stalled read.
    always_comb begin
        want_fetch = (prefetch_wr_i & (~held_valid | consume)) | rd_stall_o;
    end

    rnd_pf_fetch_ctrl i_fetch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .want_i    (want_fetch),
        .ack_i     (ent_ack_i),
        .req_o     (ent_req_o),
        .capture_o (capture)
    );

    rnd_pf_hold #(
        .W (RND_W)
    ) i_hold (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .capture_i  (capture),
        .cap_data_i (ent_data_i),
        .consume_i  (consume),
        .valid_o    (held_valid),
        .data_o     (held_data)
    );

    rnd_pf_rd_mux #(
        .WIDE_W   (RND_W),
        .NARROW_W (NARROW_W)
    ) i_mux (
        .fire_i     (consume),
        .sel_wide_i (rd_wide_i),
        .data_i     (held_data),
        .data_o     (rd_data_o)
    );

    assert_stall_requests_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stall_o && !(ent_req_o && ent_ack_i)) |=> ent_req_o);

    assert_stall_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ent_req_o && ent_ack_i) |=> !rd_stall_o);

    assert_refetch_on_consume_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prefetch_wr_i && rd_req_i && !rd_stall_o) |=> ent_req_o);

endmodule

// File: tb/test_rnd_prefetch_reg.sv
// Bench for the random-word prefetch holder: a vector table walked cycle by
// cycle, then directed tests for a long unanswered request and a mid-fetch reset.
module test_rnd_prefetch_reg;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned WW = 64;
    localparam int unsigned NW = 16;

    typedef struct packed {
        logic          pf;
        logic          rd;
        logic          wide;
        logic          ack;
        logic [WW-1:0] dat;
        logic          exp_req;
        logic          exp_stall;
        logic [WW-1:0] exp_dat;
        logic [7:0]    tag;
    } vec_t;

    localparam logic [WW-1:0] D1 = 64'hA5A5_0001_1234_5678;
    localparam logic [WW-1:0] D2 = 64'h0F0F_2222_9ABC_DEF0;
    localparam logic [WW-1:0] D3 = 64'h3333_C0DE_0000_BEEF;
    localparam logic [WW-1:0] D4 = 64'h4444_F00D_CAFE_0004;
    localparam logic [WW-1:0] D5 = 64'h5555_0000_1111_7A7A;
    localparam logic [WW-1:0] D6 = 64'h6666_6666_6666_6666;
    localparam logic [WW-1:0] D7 = 64'h7777_1357_2468_ACE1;
    localparam logic [WW-1:0] D8 = 64'h8888_0101_0202_0303;
    localparam logic [WW-1:0] Z  = '0;

    localparam int NV = 30;
    // Fields: pf rd wide ack dat | exp_req exp_stall exp_dat | requirement
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0, Z,  1'b0,1'b0, Z,  8'd1},  // R1 idle
        '{1'b1,1'b0,1'b0,1'b0, Z,  1'b0,1'b0, Z,  8'd2},  // R2 prefetch
        '{1'b0,1'b0,1'b0,1'b0, Z,  1'b1,1'b0, Z,  8'd2},  // R2 request up
        '{1'b1,1'b0,1'b0,1'b0, Z,  1'b1,1'b0, Z,  8'd3},  // R3 second prefetch
        '{1'b0,1'b0,1'b0,1'b1, D1, 1'b1,1'b0, Z,  8'd2},  // R2 ack
        '{1'b0,1'b0,1'b0,1'b0, Z,  1'b0,1'b0, Z,  8'd3},  // R3 one request only
        '{1'b1,1'b0,1'b0,1'b0, Z,  1'b0,1'b0, Z,  8'd4},  // R4 prefetch when full
        '{1'b0,1'b0,1'b0,1'b0, Z,  1'b0,1'b0, Z,  8'd4},  // R4 no request
        '{1'b0,1'b1,1'b1,1'b0, Z,  1'b0,1'b0, D1, 8'd5},  // R5 read held, R4 kept
        '{1'b0,1'b1,1'b1,1'b0, Z,  1'b0,1'b1, Z,  8'd7},  // R7 empty read stalls
        '{1'b0,1'b1,1'b1,1'b0, Z,  1'b1,1'b1, Z,  8'd7},  // R7 request issued
        '{1'b0,1'b1,1'b1,1'b1, D2, 1'b1,1'b1, Z,  8'd7},  // R7 ack while stalled
        '{1'b0,1'b1,1'b1,1'b0, Z,  1'b0,1'b0, D2, 8'd7},  // R7 returned
        '{1'b1,1'b0,1'b0,1'b0, Z,  1'b0,1'b0, Z,  8'd6},  // R6 prefetch
        '{1'b0,1'b1,1'b0,1'b0, Z,  1'b1,1'b1, Z,  8'd6},  // R6 read before arrival
        '{1'b0,1'b1,1'b0,1'b1, D3, 1'b1,1'b1, Z,  8'd6},  // R6 ack
        '{1'b0,1'b1,1'b0,1'b0, Z,  1'b0,1'b0, 64'h0000_0000_0000_BEEF, 8'd8}, // R8 narrow
        '{1'b0,1'b0,1'b0,1'b0, Z,  1'b0,1'b0, Z,  8'd5},  // R5 no read, zero data
        '{1'b1,1'b0,1'b0,1'b0, Z,  1'b0,1'b0, Z,  8'd2},  // R2 prefetch
        '{1'b0,1'b0,1'b0,1'b1, D4, 1'b1,1'b0, Z,  8'd2},  // R2 ack
        '{1'b1,1'b1,1'b1,1'b0, Z,  1'b0,1'b0, D4, 8'd9},  // R9 consume + prefetch
        '{1'b0,1'b0,1'b0,1'b0, Z,  1'b1,1'b0, Z,  8'd9},  // R9 new request
        '{1'b0,1'b0,1'b0,1'b1, D5, 1'b1,1'b0, Z,  8'd9},  // R9 ack
        '{1'b0,1'b1,1'b0,1'b0, Z,  1'b0,1'b0, 64'h0000_0000_0000_7A7A, 8'd8}, // R8 narrow
        '{1'b0,1'b0,1'b0,1'b1, D6, 1'b0,1'b0, Z,  8'd10}, // R10 stray ack
        '{1'b0,1'b1,1'b1,1'b0, Z,  1'b0,1'b1, Z,  8'd10}, // R10 nothing captured
        '{1'b0,1'b1,1'b1,1'b0, Z,  1'b1,1'b1, Z,  8'd7},  // R7 request
        '{1'b0,1'b1,1'b1,1'b1, D7, 1'b1,1'b1, Z,  8'd7},  // R7 ack
        '{1'b0,1'b1,1'b1,1'b0, Z,  1'b0,1'b0, D7, 8'd7},  // R7 returned
        '{1'b0,1'b0,1'b0,1'b0, Z,  1'b0,1'b0, Z,  8'd5}   // R5 idle
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prefetch_wr = 1'b0;
    logic          rd_req = 1'b0;
    logic          rd_wide = 1'b0;
    logic          rd_stall;
    logic [WW-1:0] rd_data;
    logic          ent_req;
    logic          ent_ack = 1'b0;
    logic [WW-1:0] ent_data = '0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rnd_prefetch_reg #(
        .RND_W    (WW),
        .NARROW_W (NW)
    ) i_rnd_prefetch_reg (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .prefetch_wr_i (prefetch_wr),
        .rd_req_i      (rd_req),
        .rd_wide_i     (rd_wide),
        .rd_stall_o    (rd_stall),
        .rd_data_o     (rd_data),
        .ent_req_o     (ent_req),
        .ent_ack_i     (ent_ack),
        .ent_data_i    (ent_data)
    );

    task automatic chk(input int tag, input string what, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic pf, input logic rd, input logic wide, input logic ack, input logic [WW-1:0] dat);
        @(negedge clk);
        prefetch_wr = pf;
        rd_req      = rd;
        rd_wide     = wide;
        ent_ack     = ack;
        ent_data    = dat;
        #1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table, one clock cycle per entry.
        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].pf, VECS[v].rd, VECS[v].wide, VECS[v].ack, VECS[v].dat);
            chk(VECS[v].tag, "ent_req_o", {63'd0, ent_req}, {63'd0, VECS[v].exp_req});
            chk(VECS[v].tag, "rd_stall_o", {63'd0, rd_stall}, {63'd0, VECS[v].exp_stall});
            chk(VECS[v].tag, "rd_data_o", rd_data, VECS[v].exp_dat);
        end

        // R2: a request left unanswered stays raised.
        drive(1'b1, 1'b0, 1'b0, 1'b0, Z);
        for (int c = 0; c < 20; c++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b0, Z);
            chk(2, "ent_req_o held", {63'd0, ent_req}, 64'd1);
        end

        // R1: reset in the middle of a fetch clears request and holder.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(1, "ent_req_o after reset", {63'd0, ent_req}, 64'd0);
        chk(1, "rd_stall_o after reset", {63'd0, rd_stall}, 64'd0);
        drive(1'b0, 1'b1, 1'b1, 1'b0, Z);
        chk(1, "read after reset stalls", {63'd0, rd_stall}, 64'd1);
        drive(1'b0, 1'b1, 1'b1, 1'b0, Z);
        chk(7, "ent_req_o after stalled read", {63'd0, ent_req}, 64'd1);
        drive(1'b0, 1'b1, 1'b1, 1'b1, D8);
        chk(6, "rd_stall_o on ack cycle", {63'd0, rd_stall}, 64'd1);
        drive(1'b0, 1'b1, 1'b1, 1'b0, Z);
        chk(6, "rd_stall_o after ack", {63'd0, rd_stall}, 64'd0);
        chk(6, "rd_data_o after ack", rd_data, D8);
        drive(1'b0, 1'b0, 1'b0, 1'b0, Z);
        chk(5, "rd_data_o idle", rd_data, Z);

        summary();
    end

endmodule